// File: doc/BRIEF.md
# DMA bridge interrupt status aggregator

This block collects the interrupt events of a DMA bridge that serves one USB DMA channel and two audio channels, each audio channel having a playback and a record direction. Ten single-cycle event pulses arrive on `evt_i`. Each pulse latches a sticky pending flag, and each event also has an enable bit. Enables and pending flags share one 32-bit control/status word, which is read and written through a simple single-cycle bus port.

Software acknowledges an event by writing 0 to its pending flag. It masks an event by writing 0 to its enable bit. Writing 1 to a flag leaves it unchanged, so a handler can write back the word it read with the serviced flags cleared. The enabled, pending events drive three registered level interrupt lines. The events are grouped onto the lines by kind: the USB address error has a line of its own, every "transfer complete" event shares a second line, and every "half complete" event shares a third.

Event numbering: event 0 is USB transfer done and event 1 is USB address error. Events 2 to 5 belong to audio channel 0 and events 6 to 9 to audio channel 1. Within each channel the order is play all-done, play half-done, record all-done, record half-done.

Top module: `xfer_irq_hub`

## Requirements
- R1: After reset, `bus_rdata` reads 0x00000000 and `irq_o` is 3'b000.
- R2: A 1 on `evt_i[e]` sets pending flag e at the next clock edge, whether or not event e is enabled. The flag of audio event e (2 to 9) reads at bit e+14. The flags of events 0 and 1 read at bits 0 and 1.
- R3: A bus write (`bus_sel`=1, `bus_we`=1) clears each pending flag whose bit in `bus_wdata` is 0. A 1 written to a flag bit leaves that flag unchanged. A flag is never set by a write.
- R4: If an event pulse arrives in the same cycle as a write that clears its flag, the flag is set after that edge.
- R5: A bus write loads every enable bit from `bus_wdata`. The enable of audio event e reads at bit e+22. The enables of events 0 and 1 read at bits 8 and 9. Without a write, the enables keep their value.
- R6: Bits 15 to 10 and 7 to 2 of `bus_rdata` always read 0 and ignore written values.
- R7: `irq_o[0]` is high in the cycle after event 1 is both pending and enabled, and is low otherwise.
- R8: `irq_o[1]` is high in the cycle after any of events 0, 2, 4, 6 or 8 is both pending and enabled, and is low otherwise.
- R9: `irq_o[2]` is high in the cycle after any of events 3, 5, 7 or 9 is both pending and enabled, and is low otherwise.
- R10: Each interrupt line is registered. It reflects the register state one clock later, and it stays high until every flag contributing to it is cleared or masked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 10 | Event pulses, bit e is event e |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write qualifier for bus_sel |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Current control/status word |
| irq_o | output | 3 | Level interrupt lines 0 to 2 |

## Verification
An event pulse and a software write that clears the same flag can fall in the same clock cycle. The block must then let the event win, so that an acknowledge never loses a fresh event. The bench forces this collision in a directed step, with an all-zero write paired with events on every input. The random phase also produces such collisions often, because events and writes are drawn on each cycle. Each cycle a bench model computes the expected word and lines from the requirements and compares them at the ports. After every collision step the flag must read as set.

// File: rtl/xfer_irq_hub.sv
module xfer_irq_hub #(
  parameter int NEVT  = 10,
  parameter int NLINE = 3,
  parameter int DW    = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NEVT-1:0] evt_i,
  input  logic            bus_sel,
  input  logic            bus_we,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic [NLINE-1:0] irq_o
);
  localparam int NAUD = NEVT - 2;
  localparam logic [DW-1:0] UNUSED = 32'h0000_FCFC;

  logic [NEVT-1:0] pend, en, act, wflag, wen;
  logic            wr;

  assign wr    = bus_sel & bus_we;
  assign wflag = {bus_wdata[16+NAUD-1:16], bus_wdata[1:0]};
  assign wen   = {bus_wdata[24+NAUD-1:24], bus_wdata[9:8]};
  assign act   = pend & en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend  <= '0;
      en    <= '0;
      irq_o <= '0;
    end else begin
      pend  <= evt_i | (pend & (wr ? wflag : {NEVT{1'b1}}));
      if (wr) en <= wen;
      irq_o[0] <= act[1];
      irq_o[1] <= act[0] | act[2] | act[4] | act[6] | act[8];
      irq_o[2] <= act[3] | act[5] | act[7] | act[9];
    end
  end

  assign bus_rdata = {en[NEVT-1:2], pend[NEVT-1:2], 6'b0, en[1:0], 6'b0, pend[1:0]};

  AST_RESET_CLEAN: assert property (@(posedge clk)
    !rst_n |=> (bus_rdata == '0 && irq_o == '0)); // R1
  AST_EVENT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((pend & $past(evt_i)) == $past(evt_i))); // R2
  AST_NO_WRITE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((pend & ~$past(pend) & ~$past(evt_i)) == '0)); // R3
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> ((pend & ~$past(wflag) & ~$past(evt_i)) == '0)); // R3
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(en)); // R5
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & UNUSED) == '0); // R6
  AST_QUIET_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    (act == '0) |=> (irq_o == '0)); // R10
  AST_LINE0_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    !act[1] |=> !irq_o[0]); // R7
endmodule

// File: tb/xfer_irq_hub_test.sv
module xfer_irq_hub_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  evt_i = '0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  irq_o;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [9:0] m_pend = '0, m_en = '0;
  logic [2:0] m_irq = '0;

  xfer_irq_hub uut (.clk(clk), .rst_n(rst_n), .evt_i(evt_i), .bus_sel(bus_sel),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o));

  always #2.5 clk = ~clk;

  function automatic logic [31:0] pack_word(input logic [9:0] en, input logic [9:0] pd);
    logic [31:0] w = '0;
    for (int e = 0; e < 10; e++) begin
      if (e < 2) begin w[e] = pd[e]; w[e+8] = en[e]; end
      else begin w[e+14] = pd[e]; w[e+22] = en[e]; end
    end
    return w;
  endfunction

  function automatic logic [2:0] lines_of(input logic [9:0] a);
    logic [2:0] l = '0;
    l[0] = a[1];
    for (int e = 0; e < 10; e++) begin
      if (e == 0 || (e >= 2 && e % 2 == 0)) l[1] |= a[e];
      if (e >= 3 && e % 2 == 1) l[2] |= a[e];
    end
    return l;
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [9:0] ev, input logic wr, input logic [31:0] wd, input string tag);
    logic [9:0] wf, we_;
    evt_i = ev; bus_sel = wr; bus_we = wr; bus_wdata = wd;
    @(posedge clk);
    wf  = {wd[23:16], wd[1:0]};
    we_ = {wd[31:24], wd[9:8]};
    m_irq  = lines_of(m_pend & m_en);
    m_pend = ev | (m_pend & (wr ? wf : 10'h3FF));
    if (wr) m_en = we_;
    @(negedge clk);
    evt_i = '0; bus_sel = 0; bus_we = 0;
    check(bus_rdata, pack_word(m_en, m_pend), {tag, " word R2/R3/R5/R6"});
    check({29'b0, irq_o[0]}, {31'b0, m_irq[0]}, {tag, " line0 R7"});
    check({29'b0, irq_o[1]}, {31'b0, m_irq[1]}, {tag, " line1 R8"});
    check({29'b0, irq_o[2]}, {31'b0, m_irq[2]}, {tag, " line2 R9 R10"});
  endtask

  initial begin
    int seed = 1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check(bus_rdata, 32'h0, "R1 word");
    check({29'b0, irq_o}, 32'h0, "R1 lines");
    rst_n = 1;
    // R6/R3: all-ones write sets only enables, no flags
    step('0, 1, 32'hFFFF_FFFF, "R6 ones");
    check(bus_rdata, 32'hFF00_0300, "R6 unused R3 no-set");
    // R2: events latch while masked, no interrupt
    step('0, 1, 32'h0, "mask");
    step(10'h3FF, 0, 0, "R2 masked events");
    check(bus_rdata, 32'h00FF_0003, "R2 flag positions");
    step('0, 0, 0, "R2 idle");
    check({29'b0, irq_o}, 32'h0, "R2 masked lines");
    // enable only event 1 -> line0
    step('0, 1, 32'h0000_0203 | 32'h00FF_0000, "R7 en1");
    step('0, 0, 0, "R7 hold");
    check({29'b0, irq_o}, 32'h1, "R7 line0 only");
    // R4 collision: clear-all write with events on every input
    step(10'h3FF, 1, 32'h0, "R4 collide");
    check(bus_rdata, 32'h00FF_0003, "R4 event wins");
    // R10: clearing drops the line one cycle later
    step('0, 1, 32'hFF00_0300, "R10 clear all");
    step('0, 0, 0, "R10 low");
    check({29'b0, irq_o}, 32'h0, "R10 lines low");
    for (int i = 0; i < 3000; i++) begin
      logic [9:0] ev = 10'($urandom) & 10'($urandom) & 10'($urandom);
      logic       w  = ($urandom % 4) == 0;
      step(ev, w, $urandom, "rand");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog R10 actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule